// File: doc/BRIEF.md
# Serial Audio Data Transmitter

This block turns stereo sample pairs into a single serial data line for a two-channel audio link. The bit clock and the frame clock come from elsewhere, either a local clock generator or external pins. The block observes both clocks in its own system-clock domain and changes the data line only after each falling edge of the bit clock. Both clocks must be synchronous to the system clock and run well below it. A static format input picks one of two framings. In MSB-justified framing the left channel occupies the frame-clock-high half, and its first bit goes out right away. In I2S-compatible framing the left channel occupies the frame-clock-low half, and every bit is one bit period later.

Samples are 24-bit two's complement and are sent most significant bit first. A producer hands over a left/right pair through a valid/ready interface. A one-entry holding register accepts the pair, and it becomes the transmitted pair at the start of the next left channel. If no new pair has arrived by then, the previous pair is sent again. The block counts bit-clock periods in every half frame. When a half frame is exactly 16 bit periods long (a 32fs bit clock), the next frame sends only the upper 16 bits of each sample. Any bit period after the last data bit of a channel is filled with zeros.

Top module: `sdtx_serial_tx`

## Requirements
- R1: While reset is asserted and right after it is released, `sdata` is 0 and `in_ready` is 1.
- R2: With `fmt_i2s`=0, the left sample is sent while `lrck` is 1 and the right sample while `lrck` is 0. The MSB goes out at the falling bit-clock edge where `lrck` takes its new level (slot 0). Bit k of the channel goes out in slot k.
- R3: With `fmt_i2s`=1, the left sample is sent while `lrck` is 0 and the right sample while `lrck` is 1. Every bit goes out one slot later than under R2, so the MSB is in slot 1. Slot 0 of a half carries the final slot value of the previous half.
- R4: Bits are sent in descending order starting at bit 23, with sample values passed unchanged as two's complement. `sdata` changes only in response to a falling edge of `bclk`.
- R5: After the last data bit of a channel, `sdata` stays 0 for the rest of that half frame.
- R6: When the previous half frame lasted exactly 16 bit periods, each channel of the frame carries 16 data bits, which are sample bits 23 down to 8.
- R7: The 16-bit/24-bit choice is made at the start of each left channel from the length of the half frame that just ended. It holds for the whole frame, so a step from 32fs back to 64fs still gives one 16-bit frame.
- R8: `in_ready` is 1 when the holding register is empty. A pair offered with `in_valid` while `in_ready` is 1 is taken on that clock edge, and `in_ready` goes to 0 in the following cycle.
- R9: If the holding register is empty at the start of a left channel, the previously transmitted pair is sent again in that frame.
- R10: Half frames of 24 or 32 bit periods (48fs, 64fs) carry all 24 bits when the previous half was not 16 bit periods long.
- R11: Until the first frame-clock transition after reset, `sdata` stays 0. A pair taken at the first left start after reset is sent in 24-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both serial clocks are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_i2s | input | 1 | 0 = MSB-justified, 1 = I2S-compatible framing |
| bclk | input | 1 | Serial bit clock |
| lrck | input | 1 | Frame (channel) clock; changes with a bit-clock falling edge |
| in_valid | input | 1 | Sample pair on `in_left`/`in_right` is valid |
| in_ready | output | 1 | Holding register can take a pair |
| in_left | input | SAMPLE_W | Left sample, two's complement |
| in_right | input | SAMPLE_W | Right sample, two's complement |
| sdata | output | 1 | Serial data, MSB first |

## Verification
Several properties are checked on every cycle. The data line stays constant except after a bit-clock falling edge, stays low before the first frame transition, and stays low in the zero-fill slots of MSB-justified framing. The holding register drops `in_ready` after an accept. The 16-bit mode flag changes only at a left-channel start. Only the bench's frame sequences can show the remaining behaviour: the exact bit order and channel-to-level mapping in both framings, the one-slot I2S shift carrying a bit across the half boundary, the replay of an unchanged pair, and the one-frame lag of the 32fs detection when the bit-clock rate changes.

// File: rtl/sdtx_pkg.sv
package sdtx_pkg;
   typedef enum logic {
      FMT_MSBJ = 1'b0,
      FMT_I2S  = 1'b1
   } sdtx_fmt_e;
endpackage

// File: rtl/sdtx_edge.sv
module sdtx_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_i,
   input  logic lrck_i,
   output logic fall_o,
   output logic lrck_o
);
   logic bclk_s, lr_s, bclk_q;

   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("sdtx_edge: SYNC_STAGES must be >= 0");
   end

   if (SYNC_STAGES == 0) begin : g_direct
      assign bclk_s = bclk_i;
      assign lr_s   = lrck_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] bq, lq;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bq <= '0;
            lq <= '0;
         end else begin
            bq[0] <= bclk_i;
            lq[0] <= lrck_i;
            for (int i = 1; i < SYNC_STAGES; i++) begin
               bq[i] <= bq[i-1];
               lq[i] <= lq[i-1];
            end
         end
      end
      assign bclk_s = bq[SYNC_STAGES-1];
      assign lr_s   = lq[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bclk_q <= 1'b0;
      else        bclk_q <= bclk_s;
   end

   assign fall_o = bclk_q & ~bclk_s;
   assign lrck_o = lr_s;
endmodule

// File: rtl/sdtx_framer.sv
module sdtx_framer #(
   parameter int SLOT_MAX = 64,
   parameter int SHORT_W  = 16,
   localparam int SLOT_BW = $clog2(SLOT_MAX + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fall_i,
   input  logic               lrck_i,
   input  logic               fmt_i,
   output logic [SLOT_BW-1:0] slot_o,
   output logic               left_o,
   output logic               left_start_o,
   output logic               short_o,
   output logic               started_o
);
   logic seen_q, prev_lr_q, trans, into_left;

   if (SHORT_W < 1 || SHORT_W > SLOT_MAX) begin : g_bad_short
      $error("sdtx_framer: SHORT_W out of range");
   end

   assign trans        = seen_q && (lrck_i != prev_lr_q);
   assign into_left    = (lrck_i != fmt_i);
   assign left_start_o = fall_i && trans && into_left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q    <= 1'b0;
         prev_lr_q <= 1'b0;
         slot_o    <= '0;
         left_o    <= 1'b0;
         short_o   <= 1'b0;
         started_o <= 1'b0;
      end else if (fall_i) begin
         seen_q    <= 1'b1;
         prev_lr_q <= lrck_i;
         if (trans) begin
            slot_o    <= '0;
            left_o    <= into_left;
            started_o <= 1'b1;
            if (into_left)
               short_o <= started_o && (slot_o == SLOT_BW'(SHORT_W - 1));
         end else if (slot_o != SLOT_BW'(SLOT_MAX)) begin
            slot_o <= slot_o + 1'b1;
         end
      end
   end

   p_width_at_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(short_o) |-> $past(left_start_o));
endmodule

// File: rtl/sdtx_stage.sv
module sdtx_stage #(
   parameter int SAMPLE_W = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                valid_i,
   output logic                ready_o,
   input  logic [SAMPLE_W-1:0] left_i,
   input  logic [SAMPLE_W-1:0] right_i,
   input  logic                load_i,
   output logic [SAMPLE_W-1:0] cur_l_o,
   output logic [SAMPLE_W-1:0] cur_r_o
);
   logic                full_q;
   logic [SAMPLE_W-1:0] hold_l, hold_r;

   assign ready_o = !full_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q  <= 1'b0;
         hold_l  <= '0;
         hold_r  <= '0;
         cur_l_o <= '0;
         cur_r_o <= '0;
      end else begin
         if (load_i && full_q) begin
            cur_l_o <= hold_l;
            cur_r_o <= hold_r;
            full_q  <= 1'b0;
         end
         if (valid_i && !full_q) begin
            hold_l <= left_i;
            hold_r <= right_i;
            full_q <= 1'b1;
         end
      end
   end

   p_accept_fills_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && ready_o) |=> !ready_o);
endmodule

// File: rtl/sdtx_serial_tx.sv
module sdtx_serial_tx #(
   parameter int SAMPLE_W    = 24,
   parameter int SHORT_W     = 16,
   parameter int SLOT_MAX    = 64,
   parameter int SYNC_STAGES = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fmt_i2s,
   input  logic                bclk,
   input  logic                lrck,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [SAMPLE_W-1:0] in_left,
   input  logic [SAMPLE_W-1:0] in_right,
   output logic                sdata
);
   import sdtx_pkg::*;
   localparam int SLOT_BW = $clog2(SLOT_MAX + 1);

   if (SHORT_W >= SAMPLE_W || SAMPLE_W > SLOT_MAX) begin : g_bad_widths
      $error("sdtx_serial_tx: need SHORT_W < SAMPLE_W <= SLOT_MAX");
   end

   logic               fall, lr_s, fall_d, left_start;
   logic               is_left, short_m, started, mj_bit, mj_prev;
   logic [SLOT_BW-1:0] slot, nbits;
   logic [SAMPLE_W-1:0] cur_l, cur_r, word, shifted;
   sdtx_fmt_e          fmt;

   assign fmt = sdtx_fmt_e'(fmt_i2s);

   sdtx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .lrck_i(lrck),
      .fall_o(fall), .lrck_o(lr_s));

   sdtx_framer #(.SLOT_MAX(SLOT_MAX), .SHORT_W(SHORT_W)) u_framer (
      .clk(clk), .rst_n(rst_n), .fall_i(fall), .lrck_i(lr_s),
      .fmt_i(fmt_i2s), .slot_o(slot), .left_o(is_left),
      .left_start_o(left_start), .short_o(short_m), .started_o(started));

   sdtx_stage #(.SAMPLE_W(SAMPLE_W)) u_stage (
      .clk(clk), .rst_n(rst_n), .valid_i(in_valid), .ready_o(in_ready),
      .left_i(in_left), .right_i(in_right), .load_i(left_start),
      .cur_l_o(cur_l), .cur_r_o(cur_r));

   assign nbits   = short_m ? SLOT_BW'(SHORT_W) : SLOT_BW'(SAMPLE_W);
   assign word    = is_left ? cur_l : cur_r;
   assign shifted = word << slot;
   assign mj_bit  = started && (slot < nbits) && shifted[SAMPLE_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fall_d  <= 1'b0;
         sdata   <= 1'b0;
         mj_prev <= 1'b0;
      end else begin
         fall_d <= fall;
         if (fall_d) begin
            mj_prev <= mj_bit;
            sdata   <= (fmt == FMT_I2S) ? mj_prev : mj_bit;
         end
      end
   end

   p_edge_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !fall_d |=> $stable(sdata));

   p_zero_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_d && fmt == FMT_MSBJ && slot >= nbits) |=> !sdata);

   p_idle_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !started |-> !sdata);
endmodule

// File: tb/sim_sdtx_serial_tx.sv
module sim_sdtx_serial_tx;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fmt_i2s = 1'b0;
   logic        bclk = 1'b1;
   logic        lrck = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [23:0] in_left = '0;
   logic [23:0] in_right = '0;
   logic        sdata;

   int checks = 0;
   int fails  = 0;

   logic [23:0] m_cur_l, m_cur_r, m_pend_l, m_pend_r;
   logic        m_pend, m_started, m_prevlast;
   int          m_last_slots;

   always #2.5 clk = ~clk;

   sdtx_serial_tx u0 (
      .clk(clk), .rst_n(rst_n), .fmt_i2s(fmt_i2s), .bclk(bclk), .lrck(lrck),
      .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left),
      .in_right(in_right), .sdata(sdata));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic mjb(input logic [23:0] w, input int nb, input int s);
      if (s < 0 || s >= nb) return 1'b0;
      return w[23 - s];
   endfunction

   task automatic run_half(input logic lv, input int n, output logic [63:0] got);
      got = '0;
      for (int s = 0; s < n; s++) begin
         @(negedge clk);
         bclk = 1'b0;
         lrck = lv;
         repeat (3) @(negedge clk);
         got[s] = sdata;
         bclk = 1'b1;
         repeat (2) @(negedge clk);
      end
   endtask

   // one channel half: expected stream from R2/R3/R5/R6
   task automatic half(input string req, input logic lv, input int n,
                       input logic [23:0] w, input int nb);
      logic [63:0] got, exp;
      exp = '0;
      for (int s = 0; s < n; s++)
         exp[s] = fmt_i2s ? ((s == 0) ? m_prevlast : mjb(w, nb, s - 1)) : mjb(w, nb, s);
      run_half(lv, n, got);
      m_prevlast   = mjb(w, nb, n - 1);
      m_last_slots = n;
      chk(req, got, exp);
   endtask

   task automatic offer(input logic [23:0] l, input logic [23:0] r);
      @(negedge clk);
      chk("R8 ready before offer", {63'd0, in_ready}, 64'd1);
      in_valid = 1'b1; in_left = l; in_right = r;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R8 ready drops after accept", {63'd0, in_ready}, 64'd0);
      m_pend = 1'b1; m_pend_l = l; m_pend_r = r;
   endtask

   task automatic frame(input string req, input int n);
      int nb;
      nb = (m_started && m_last_slots == 16) ? 16 : 24;
      if (m_pend) begin
         m_cur_l = m_pend_l; m_cur_r = m_pend_r; m_pend = 1'b0;
      end
      m_started = 1'b1;
      half(req, ~fmt_i2s, n, m_cur_l, nb);
      half(req, fmt_i2s, n, m_cur_r, nb);
   endtask

   task automatic run_format(input logic f);
      logic [63:0] got;
      rst_n = 1'b0; fmt_i2s = f; bclk = 1'b1; lrck = f; in_valid = 1'b0;
      m_cur_l = '0; m_cur_r = '0; m_pend = 1'b0; m_started = 1'b0;
      m_prevlast = 1'b0; m_last_slots = 0;
      repeat (4) @(negedge clk);
      chk("R1 sdata in reset", {63'd0, sdata}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready after reset", {63'd0, in_ready}, 64'd1);
      run_half(f, 5, got);
      chk("R11 idle before first transition", got, 64'd0);
      for (int k = 0; k < 8; k++) begin
         logic [23:0] l, r;
         l = 24'h800001 ^ (24'(k) * 24'h13579B) ^ (f ? 24'h5A5A5A : 24'h0);
         r = ~l + 24'(k * 7);
         case (k)
            0: begin offer(l, r); frame(f ? "R3 64fs" : "R2 R4 64fs", 32); end
            1: begin offer(l, r); frame("R10 48fs full width", 24); end
            2: frame("R9 repeat pair", 32);
            3: begin offer(l, r); frame("R6 32fs first frame", 16); end
            4: begin offer(l, r); frame("R6 32fs upper bits", 16); end
            5: begin offer(l, r); frame("R7 one short frame after 32fs", 32); end
            6: frame("R9 R10 repeat full width", 32);
            default: begin offer(l, r); frame("R5 zero fill 48fs", 24); end
         endcase
      end
   endtask

   initial begin
      run_format(1'b0);
      run_format(1'b1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule